// File: doc/BRIEF.md
# Three-Dimensional DMA Address Sequencer

The sequencer walks one transfer described by a parameter set and produces, for every byte, a read (source) address and a write (destination) address. A transfer is a block of C frames; each frame holds B arrays; each array holds A contiguous bytes. Each side has its own signed stride between arrays and its own signed stride between frames. Either side may instead be held on a fixed FIFO location, where only the byte lane inside one FIFO word changes.

Transfers advance on trigger events. In array mode one trigger moves one array. In frame mode one trigger moves a whole frame. In array mode the B count of every frame after the first comes from a separate reload value. Bytes leave one per cycle under a valid/ready handshake. When the block is finished, the block reports a completion pulse together with a 6-bit completion code. The interrupt flavour of that pulse is gated by an enable. A trigger that arrives while bytes of an earlier event are still being issued is reported as missed and is dropped.

Top module: `dma3d_addr_seq`

## Requirements
- R1: After reset, req_valid_o, busy_o, missed_o, done_o and done_int_o are all 0.
- R2: On a side not in constant mode, byte k of an array (k = 0..A-1) carries the address array_start + k. The addresses advance only on a cycle where req_valid_o and req_ready_i are both 1, and they hold while req_ready_i is 0.
- R3: Within a frame, each array starts at the previous array's start plus that side's 16-bit B stride. The stride is sign-extended, so it may be negative.
- R4: With sync_frame_i = 1, the first array of the next frame starts at the start of the previous frame plus that side's sign-extended C stride.
- R5: With sync_frame_i = 0, the first array of the next frame starts at the start of the last array of the previous frame plus the sign-extended C stride.
- R6: With sync_frame_i = 0, each trigger produces exactly A accepted bytes. After them, req_valid_o stays 0 until the next trigger.
- R7: With sync_frame_i = 1, each trigger produces exactly A×B accepted bytes. After them, req_valid_o stays 0 until the next trigger.
- R8: With sync_frame_i = 0, the first frame has B arrays and every later frame has bcnt_rld_i arrays.
- R9: A side in constant mode issues base + (k mod 2^fw) for byte k of each array. Here fw is the 2-bit width code: 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8. Its B and C strides have no effect.
- R10: In the cycle after the final byte of the block is accepted, done_o is 1 for exactly one cycle and busy_o is 0. In that cycle done_code_o equals the code sampled at the starting trigger. done_int_o equals done_o AND the enable sampled at that trigger.
- R11: A trigger sampled while req_valid_o is 1 makes missed_o 1 in the next cycle. This includes the cycle of the final byte. The trigger is not queued: no further bytes are issued without a new trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger event, one cycle |
| sync_frame_i | input | 1 | 1: frame per trigger, 0: array per trigger |
| src_base_i | input | 32 | Source start address |
| dst_base_i | input | 32 | Destination start address |
| acnt_i | input | 16 | Bytes per array (at least 1) |
| bcnt_i | input | 16 | Arrays per frame (at least 1) |
| ccnt_i | input | 16 | Frames per block (at least 1) |
| bcnt_rld_i | input | 16 | Arrays per frame after the first, array mode |
| src_bidx_i | input | 16 | Signed source array stride |
| dst_bidx_i | input | 16 | Signed destination array stride |
| src_cidx_i | input | 16 | Signed source frame stride |
| dst_cidx_i | input | 16 | Signed destination frame stride |
| src_const_i | input | 1 | Source held at a FIFO address |
| dst_const_i | input | 1 | Destination held at a FIFO address |
| src_fw_i | input | 2 | Source FIFO width code |
| dst_fw_i | input | 2 | Destination FIFO width code |
| cmpl_en_i | input | 1 | Completion interrupt enable |
| cmpl_code_i | input | 6 | Completion code |
| req_ready_i | input | 1 | Byte request accepted |
| req_valid_o | output | 1 | Byte request pending |
| rd_addr_o | output | 32 | Source byte address |
| wr_addr_o | output | 32 | Destination byte address |
| busy_o | output | 1 | Block in progress |
| missed_o | output | 1 | Trigger dropped, one-cycle pulse |
| done_o | output | 1 | Block finished, one-cycle pulse |
| done_int_o | output | 1 | Completion interrupt pulse |
| done_code_o | output | 6 | Completion code of the finished block |

## Verification
Two things can happen in the same cycle: the acceptance of the block's final byte and a new trigger. The final byte ends the block and raises done_o. The new trigger must be judged a missed event, because req_valid_o is still 1 in that cycle. The bench drives the trigger exactly on the cycle of the last beat of a one-frame block. In the next cycle it expects done_o and missed_o both at 1, with busy_o and req_valid_o both at 0. For several cycles after that it expects req_valid_o to stay 0, which shows that the trigger was neither queued nor taken as the start of a new block.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;
  typedef enum logic {SYNC_ARRAY = 1'b0, SYNC_FRAME = 1'b1} sync_e;

  // byte-lane mask for a FIFO width code: 1, 2, 4 or 8 bytes
  function automatic logic [7:0] lane_mask(input logic [1:0] fw);
    return 8'((1 << fw) - 1);
  endfunction
endpackage

// File: rtl/dma3d_span_ctl.sv
module dma3d_span_ctl
  import dma3d_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             beat_i,
  input  sync_e            mode_i,
  input  logic [CNT_W-1:0] acnt_i,
  input  logic [CNT_W-1:0] bcnt_i,
  input  logic [CNT_W-1:0] ccnt_i,
  input  logic [CNT_W-1:0] rld_i,
  output logic             load_o,
  output logic             active_o,
  output logic             xfer_o,
  output logic [CNT_W-1:0] a_idx_o,
  output logic             arr_step_o,
  output logic             frm_step_o,
  output logic             blk_end_o,
  output logic             missed_o
);
  sync_e            mode_q;
  logic [CNT_W-1:0] acnt_q, bcnt_q, rld_q;
  logic [CNT_W-1:0] a_idx_q, b_rem_q, c_rem_q;
  logic             active_q, xfer_q, missed_q;
  logic             last_a, last_b, last_c, arr_done, frm_done, ev_done;

  assign load_o   = trig_i & ~active_q;
  assign last_a   = (a_idx_q == acnt_q - CNT_W'(1));
  assign last_b   = (b_rem_q == CNT_W'(1));
  assign last_c   = (c_rem_q == CNT_W'(1));
  assign arr_done = beat_i & last_a;
  assign frm_done = arr_done & last_b;
  assign ev_done  = (mode_q == SYNC_FRAME) ? frm_done : arr_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= SYNC_ARRAY;
      acnt_q   <= '0;
      bcnt_q   <= '0;
      rld_q    <= '0;
      a_idx_q  <= '0;
      b_rem_q  <= '0;
      c_rem_q  <= '0;
      active_q <= 1'b0;
      xfer_q   <= 1'b0;
      missed_q <= 1'b0;
    end else begin
      missed_q <= trig_i & xfer_q;
      if (load_o) begin
        mode_q   <= mode_i;
        acnt_q   <= acnt_i;
        bcnt_q   <= bcnt_i;
        rld_q    <= rld_i;
        a_idx_q  <= '0;
        b_rem_q  <= bcnt_i;
        c_rem_q  <= ccnt_i;
        active_q <= 1'b1;
        xfer_q   <= 1'b1;
      end else begin
        if (trig_i && active_q && !xfer_q) xfer_q <= 1'b1;
        if (beat_i) a_idx_q <= last_a ? '0 : a_idx_q + CNT_W'(1);
        if (arr_done) begin
          if (last_b) begin
            // array mode refills from the reload value, frame mode from B
            b_rem_q <= (mode_q == SYNC_FRAME) ? bcnt_q : rld_q;
            if (last_c) active_q <= 1'b0;
            else        c_rem_q  <= c_rem_q - CNT_W'(1);
          end else begin
            b_rem_q <= b_rem_q - CNT_W'(1);
          end
        end
        if (ev_done) xfer_q <= 1'b0;
      end
    end
  end

  assign active_o   = active_q;
  assign xfer_o     = xfer_q;
  assign a_idx_o    = a_idx_q;
  assign arr_step_o = arr_done & ~last_b;
  assign frm_step_o = frm_done;
  assign blk_end_o  = frm_done & last_c;
  assign missed_o   = missed_q;
endmodule

// File: rtl/dma3d_side_gen.sv
module dma3d_side_gen
  import dma3d_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  sync_e            mode_i,
  input  logic [AW-1:0]    base_i,
  input  logic [IDX_W-1:0] bidx_i,
  input  logic [IDX_W-1:0] cidx_i,
  input  logic             const_i,
  input  logic [1:0]       fw_i,
  input  logic [CNT_W-1:0] a_idx_i,
  input  logic             arr_step_i,
  input  logic             frm_step_i,
  output logic [AW-1:0]    addr_o
);
  localparam int EXT_W = AW - IDX_W;

  sync_e         mode_q;
  logic [AW-1:0] base_q, bidx_q, cidx_q, arr_q, frm_q, nxt_frm;
  logic          const_q;
  logic [1:0]    fw_q;

  // frame mode strides from the previous frame start, array mode from the last array
  assign nxt_frm = ((mode_q == SYNC_FRAME) ? frm_q : arr_q) + cidx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= SYNC_ARRAY;
      base_q  <= '0;
      bidx_q  <= '0;
      cidx_q  <= '0;
      arr_q   <= '0;
      frm_q   <= '0;
      const_q <= 1'b0;
      fw_q    <= '0;
    end else if (load_i) begin
      mode_q  <= mode_i;
      base_q  <= base_i;
      bidx_q  <= {{EXT_W{bidx_i[IDX_W-1]}}, bidx_i};
      cidx_q  <= {{EXT_W{cidx_i[IDX_W-1]}}, cidx_i};
      arr_q   <= base_i;
      frm_q   <= base_i;
      const_q <= const_i;
      fw_q    <= fw_i;
    end else if (frm_step_i) begin
      arr_q <= nxt_frm;
      frm_q <= nxt_frm;
    end else if (arr_step_i) begin
      arr_q <= arr_q + bidx_q;
    end
  end

  assign addr_o = const_q ? base_q + (AW'(a_idx_i) & AW'(lane_mask(fw_q)))
                          : arr_q + AW'(a_idx_i);
endmodule

// File: rtl/dma3d_addr_seq.sv
module dma3d_addr_seq
  import dma3d_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 16,
  parameter int CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              sync_frame_i,
  input  logic [AW-1:0]     src_base_i,
  input  logic [AW-1:0]     dst_base_i,
  input  logic [CNT_W-1:0]  acnt_i,
  input  logic [CNT_W-1:0]  bcnt_i,
  input  logic [CNT_W-1:0]  ccnt_i,
  input  logic [CNT_W-1:0]  bcnt_rld_i,
  input  logic [IDX_W-1:0]  src_bidx_i,
  input  logic [IDX_W-1:0]  dst_bidx_i,
  input  logic [IDX_W-1:0]  src_cidx_i,
  input  logic [IDX_W-1:0]  dst_cidx_i,
  input  logic              src_const_i,
  input  logic              dst_const_i,
  input  logic [1:0]        src_fw_i,
  input  logic [1:0]        dst_fw_i,
  input  logic              cmpl_en_i,
  input  logic [CODE_W-1:0] cmpl_code_i,
  input  logic              req_ready_i,
  output logic              req_valid_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic              busy_o,
  output logic              missed_o,
  output logic              done_o,
  output logic              done_int_o,
  output logic [CODE_W-1:0] done_code_o
);
  sync_e             mode;
  logic              load, active, xfer, beat, arr_step, frm_step, blk_end;
  logic [CNT_W-1:0]  a_idx;
  logic              done_q, int_en_q;
  logic [CODE_W-1:0] code_q;

  assign mode = sync_e'(sync_frame_i);
  assign beat = xfer & req_ready_i;

  dma3d_span_ctl #(.CNT_W(CNT_W)) u_span (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_i),
    .beat_i     (beat),
    .mode_i     (mode),
    .acnt_i     (acnt_i),
    .bcnt_i     (bcnt_i),
    .ccnt_i     (ccnt_i),
    .rld_i      (bcnt_rld_i),
    .load_o     (load),
    .active_o   (active),
    .xfer_o     (xfer),
    .a_idx_o    (a_idx),
    .arr_step_o (arr_step),
    .frm_step_o (frm_step),
    .blk_end_o  (blk_end),
    .missed_o   (missed_o)
  );

  dma3d_side_gen #(.AW(AW), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .mode_i     (mode),
    .base_i     (src_base_i),
    .bidx_i     (src_bidx_i),
    .cidx_i     (src_cidx_i),
    .const_i    (src_const_i),
    .fw_i       (src_fw_i),
    .a_idx_i    (a_idx),
    .arr_step_i (arr_step),
    .frm_step_i (frm_step),
    .addr_o     (rd_addr_o)
  );

  dma3d_side_gen #(.AW(AW), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .mode_i     (mode),
    .base_i     (dst_base_i),
    .bidx_i     (dst_bidx_i),
    .cidx_i     (dst_cidx_i),
    .const_i    (dst_const_i),
    .fw_i       (dst_fw_i),
    .a_idx_i    (a_idx),
    .arr_step_i (arr_step),
    .frm_step_i (frm_step),
    .addr_o     (wr_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      int_en_q <= 1'b0;
      code_q   <= '0;
    end else begin
      done_q <= blk_end;
      if (load) begin
        int_en_q <= cmpl_en_i;
        code_q   <= cmpl_code_i;
      end
    end
  end

  assign req_valid_o = xfer;
  assign busy_o      = active;
  assign done_o      = done_q;
  assign done_int_o  = done_q & int_en_q;
  assign done_code_o = code_q;
endmodule

// File: rtl/dma3d_addr_seq_chk.sv
module dma3d_addr_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          trig_i,
  input logic          req_ready_i,
  input logic          req_valid_o,
  input logic [AW-1:0] rd_addr_o,
  input logic [AW-1:0] wr_addr_o,
  input logic          busy_o,
  input logic          missed_o,
  input logic          done_o,
  input logic          done_int_o
);
  p_hold_on_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> $stable(rd_addr_o) && $stable(wr_addr_o));

  p_valid_in_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> busy_o);

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !req_valid_o);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_int_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_int_o |-> done_o);

  p_missed_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    missed_o |-> $past(trig_i && req_valid_o));
endmodule

bind dma3d_addr_seq dma3d_addr_seq_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trig_i      (trig_i),
  .req_ready_i (req_ready_i),
  .req_valid_o (req_valid_o),
  .rd_addr_o   (rd_addr_o),
  .wr_addr_o   (wr_addr_o),
  .busy_o      (busy_o),
  .missed_o    (missed_o),
  .done_o      (done_o),
  .done_int_o  (done_int_o)
);

// File: tb/dma3d_addr_seq_bench.sv
`timescale 1ns/1ps
module dma3d_addr_seq_bench;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        trig = 0, sfrm = 0, sconst = 0, dconst = 0, cen = 0, ready = 0;
  logic [31:0] sbase = 0, dbase = 0;
  logic [15:0] acnt = 1, bcnt = 1, ccnt = 1, rld = 1;
  logic [15:0] sbi = 0, dbi = 0, sci = 0, dci = 0;
  logic [1:0]  sfw = 0, dfw = 0;
  logic [5:0]  code = 0;
  logic        valid, busy, missed, done, dint;
  logic [31:0] rd, wr;
  logic [5:0]  dcode;

  int checks = 0, errors = 0, cyc = 0;
  bit stall_en = 0, finished = 0;

  dma3d_addr_seq u_dma3d_addr_seq (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .sync_frame_i(sfrm),
    .src_base_i(sbase), .dst_base_i(dbase), .acnt_i(acnt), .bcnt_i(bcnt),
    .ccnt_i(ccnt), .bcnt_rld_i(rld), .src_bidx_i(sbi), .dst_bidx_i(dbi),
    .src_cidx_i(sci), .dst_cidx_i(dci), .src_const_i(sconst),
    .dst_const_i(dconst), .src_fw_i(sfw), .dst_fw_i(dfw), .cmpl_en_i(cen),
    .cmpl_code_i(code), .req_ready_i(ready), .req_valid_o(valid),
    .rd_addr_o(rd), .wr_addr_o(wr), .busy_o(busy), .missed_o(missed),
    .done_o(done), .done_int_o(dint), .done_code_o(dcode)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // wait for one accepted byte and compare both addresses
  task automatic beat(string req, logic [31:0] es, logic [31:0] ed);
    int guard = 0;
    bit held = 0;
    logic [31:0] hs = 0, hd = 0;
    forever begin
      cyc++;
      ready = !(stall_en && (cyc % 3 == 1));
      #1;
      if (held) begin
        chk("R2", "stall hold src", rd, hs);
        chk("R2", "stall hold dst", wr, hd);
        held = 0;
      end
      if (valid && ready) begin
        chk(req, "src addr", rd, es);
        chk(req, "dst addr", wr, ed);
        @(negedge clk);
        break;
      end
      if (valid && !ready) begin hs = rd; hd = wr; held = 1; end
      guard++;
      if (guard > 40) begin chk(req, "beat timeout", 0, 1); break; end
      @(negedge clk);
    end
  endtask

  task automatic pulse_trig();
    trig = 1;
    @(negedge clk);
    trig = 0;
  endtask

  task automatic run_xfer(string req, bit frm, int a, int b, int c, int rl,
                          logic [31:0] s0, logic [31:0] d0,
                          logic [15:0] sb, logic [15:0] db,
                          logic [15:0] sc, logic [15:0] dc,
                          bit scn, bit dcn, logic [1:0] sw, logic [1:0] dw,
                          bit en, logic [5:0] cd);
    logic [31:0] sa, da, sf, df;
    string ev = frm ? "R7" : "R6";
    @(negedge clk);
    sfrm = frm; acnt = 16'(a); bcnt = 16'(b); ccnt = 16'(c); rld = 16'(rl);
    sbase = s0; dbase = d0; sbi = sb; dbi = db; sci = sc; dci = dc;
    sconst = scn; dconst = dcn; sfw = sw; dfw = dw; cen = en; code = cd;
    sa = s0; da = d0; sf = s0; df = d0;
    for (int ci = 0; ci < c; ci++) begin
      int nb = (ci == 0 || frm) ? b : rl;
      for (int bi = 0; bi < nb; bi++) begin
        if (!frm || bi == 0) pulse_trig();
        for (int ai = 0; ai < a; ai++)
          beat(req, scn ? s0 + (32'(ai) & ((32'd1 << sw) - 1)) : sa + 32'(ai),
                    dcn ? d0 + (32'(ai) & ((32'd1 << dw) - 1)) : da + 32'(ai));
        if (!frm || bi == nb - 1) begin
          bit last = (ci == c - 1) && (bi == nb - 1);
          chk(ev, "valid after event", valid, 0);
          if (last) begin
            chk("R10", "done", done, 1);
            chk("R10", "busy at done", busy, 0);
            chk("R10", "code", dcode, cd);
            chk("R10", "int", dint, en);
          end else begin
            chk("R10", "early done", done, 0);
            repeat (2) @(negedge clk);
            chk(ev, "no bytes without trigger", valid, 0);
          end
        end
        if (bi != nb - 1) begin
          sa = sa + {{16{sb[15]}}, sb};
          da = da + {{16{db[15]}}, db};
        end
      end
      if (frm) begin
        sf = sf + {{16{sc[15]}}, sc}; sa = sf;
        df = df + {{16{dc[15]}}, dc}; da = df;
      end else begin
        sa = sa + {{16{sc[15]}}, sc}; sf = sa;
        da = da + {{16{dc[15]}}, dc}; df = da;
      end
    end
    @(negedge clk);
    chk("R10", "done one cycle", done, 0);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", valid, 0);
    chk("R1", "busy in reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "valid", valid, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "missed", missed, 0);
    chk("R1", "done", done, 0);
    chk("R1", "int", dint, 0);
  endtask

  task automatic t_frame_strides();
    run_xfer("R3,R4", 1, 3, 3, 2, 1, 32'h1000, 32'h8000, 16'd8, 16'hFFFC,
             16'h0040, 16'hFF00, 0, 0, 2'd0, 2'd0, 1, 6'd37);
  endtask

  task automatic t_array_reload();
    run_xfer("R8,R5", 0, 2, 2, 3, 3, 32'h2000, 32'h3000, 16'h0010, 16'd4,
             16'hFFF8, 16'h0020, 0, 0, 2'd0, 2'd0, 1, 6'd63);
  endtask

  task automatic t_array_cstride();
    run_xfer("R5", 0, 1, 2, 2, 2, 32'h0500, 32'h0600, 16'd2, 16'hFFFE,
             16'h0100, 16'h0003, 0, 0, 2'd0, 2'd0, 1, 6'd0);
  endtask

  task automatic t_const_src();
    run_xfer("R9", 1, 6, 2, 2, 1, 32'h4000_0010, 32'h9000, 16'h0055, 16'd6,
             16'h0077, 16'h0010, 1, 0, 2'd2, 2'd0, 0, 6'd12);
  endtask

  task automatic t_stall_const_dst();
    stall_en = 1;
    run_xfer("R2,R9", 0, 3, 2, 1, 2, 32'h7000, 32'h5000_0020, 16'd16, 16'h0033,
             16'd0, 16'h0044, 0, 1, 2'd0, 2'd1, 1, 6'd9);
    stall_en = 0;
  endtask

  task automatic t_missed();
    @(negedge clk);
    sfrm = 1; acnt = 4; bcnt = 1; ccnt = 1; sbase = 32'hA000; dbase = 32'hB000;
    sconst = 0; dconst = 0; cen = 1; code = 6'd21;
    pulse_trig();
    ready = 0; trig = 1;
    @(negedge clk);
    trig = 0;
    chk("R11", "missed mid-event", missed, 1);
    for (int i = 0; i < 4; i++) beat("R11", 32'hA000 + 32'(i), 32'hB000 + 32'(i));
    chk("R11", "done", done, 1);
    repeat (3) @(negedge clk);
    chk("R11", "not queued valid", valid, 0);
    chk("R11", "not queued busy", busy, 0);
  endtask

  task automatic t_collision();
    @(negedge clk);
    sfrm = 1; acnt = 2; bcnt = 1; ccnt = 1; sbase = 32'hC000; dbase = 32'hD000;
    cen = 1; code = 6'd5;
    pulse_trig();
    ready = 1;
    chk("R11", "first byte", rd, 32'hC000);
    @(negedge clk);
    chk("R11", "last byte", rd, 32'hC001);
    trig = 1;
    @(negedge clk);
    trig = 0;
    chk("R11", "missed on last beat", missed, 1);
    chk("R10", "done on last beat", done, 1);
    chk("R10", "busy cleared", busy, 0);
    chk("R11", "valid cleared", valid, 0);
    repeat (3) @(negedge clk);
    chk("R11", "no restart", valid, 0);
    chk("R11", "still idle", busy, 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_frame_strides();
    t_array_reload();
    t_array_cstride();
    t_const_src();
    t_stall_const_dst();
    t_missed();
    t_collision();
    finished = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end
endmodule